// File: doc/BRIEF.md
# Serial Flash Power-On Unlock Sequencer

This block is a small SPI master that runs once after reset. It removes the write protection of an attached serial flash before any other agent touches the device, so the whole array becomes readable, writable and erasable. When configured to, it first sends a status-register write-enable command, using either 50h or 06h. It then writes a single zero byte to the status register. After that it reads the status register repeatedly until the busy flag clears, and checks that the protection field reads back as zero.

The outcome is reported on two sticky flags. `done` means the flash is unlocked and free for use. `fail` means either the protection bits stayed set or the device stayed busy for too long. Other flash masters should wait for one of the two flags. The SPI clock is the system clock divided by an even parameter, and the interface runs in SPI mode 0.

Top module: `flash_unlock_seq`

## Requirements
- R1: While reset is held, `cs_n` is 1, `sck` is 0, and `done` and `fail` are 0. After reset is released, the sequence starts with no other stimulus.
- R2: Frames use SPI mode 0. `sck` idles low. `mosi` changes only while `sck` is low, and each byte goes out most significant bit first. `miso` is taken on the rising `sck` edge.
- R3: Within a frame, consecutive rising `sck` edges are `CLK_DIV` system clocks apart.
- R4: With `wsr_en_step`=1 and `wsr_use_50h`=0, the first frame is the single 8-bit opcode 06h.
- R5: With `wsr_en_step`=1 and `wsr_use_50h`=1, the first frame is the single 8-bit opcode 50h.
- R6: With `wsr_en_step`=0, no enable frame is sent, neither 06h nor 50h. The first frame is the unlock write.
- R7: The unlock write is a single 16-bit frame inside one `cs_n` low period: opcode 01h followed by data byte 00h.
- R8: Each status poll is a 16-bit frame: opcode 05h followed by a 00h filler byte. The byte on `miso` during the second byte is the status, and bit 0 of the status means busy.
- R9: Between frames, and before the first frame, `cs_n` stays high for at least `GAP_SCK`*`CLK_DIV` system clocks.
- R10: When a poll returns busy=0 and status bits [5:2] equal 0, `done` is set. It rises in the same clock in which `cs_n` rises at the end of that poll. Bits 7, 6 and 1 are ignored.
- R11: When a poll returns busy=0 and any of status bits [5:2] is 1, `fail` is set, with the same timing as R10.
- R12: If `POLL_LIMIT` polls in a row return busy=1, `fail` is set at the end of the last of them. A run in which busy clears on poll `POLL_LIMIT`-1 or earlier still reaches `done`.
- R13: `done` and `fail` are never both 1. Once set, a flag holds until reset, and no further frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wsr_en_step | input | 1 | 1: send a status write-enable frame before the unlock write |
| wsr_use_50h | input | 1 | Selects the enable opcode: 1 for 50h, 0 for 06h |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | SPI clock, mode 0 |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| done | output | 1 | Sticky: unlock verified |
| fail | output | 1 | Sticky: protection not cleared, or busy timeout |

## Verification
A frame's bytes are only known once `cs_n` rises. The monitor therefore compares each completed frame against the head of the expected-frame queue on that rising edge. It also checks the `cs_n` high gap on the next falling edge, and the `sck` period on each rising edge from timestamps.

The verdict flag is due in the same system clock in which `cs_n` rises after the deciding poll. When that rise empties the queue, the bench checks the flags at the following falling system-clock edge. It then idles for many SCK periods, so that any extra frame, or any flag that drops, is also reported.

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq #(
  parameter int CLK_DIV    = 4,
  parameter int GAP_SCK    = 2,
  parameter int POLL_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wsr_en_step,
  input  logic wsr_use_50h,
  input  logic miso,
  output logic sck,
  output logic cs_n,
  output logic mosi,
  output logic done,
  output logic fail
);
  localparam int HALF      = CLK_DIV / 2;
  localparam int HW        = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int GAP_TICKS = 2 * GAP_SCK;
  localparam int GW        = $clog2(GAP_TICKS + 1);
  localparam int PW        = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {CMD_WREN, CMD_WRSR, CMD_RDSR} cmd_e;
  typedef enum logic [1:0] {PH_GAP, PH_XFER, PH_END} phase_e;

  logic [HW-1:0] hcnt;
  logic [GW-1:0] gcnt;
  logic [PW-1:0] polls;
  logic [15:0]   tx;
  logic [7:0]    rx;
  logic [3:0]    bits;
  cmd_e          cmd, nxt_cmd;
  phase_e        phase;
  logic          tick, long_frame;
  logic [15:0]   frame_word;

  assign tick = (hcnt == HW'(HALF - 1));
  assign mosi = tx[15];
  assign nxt_cmd = (cmd == CMD_WREN && !wsr_en_step) ? CMD_WRSR : cmd;
  assign long_frame = (cmd != CMD_WREN);

  always_comb begin
    case (nxt_cmd)
      CMD_WREN: frame_word = {(wsr_use_50h ? 8'h50 : 8'h06), 8'h00};
      CMD_WRSR: frame_word = 16'h0100;
      default:  frame_word = 16'h0500;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      gcnt  <= '0;
      polls <= '0;
      tx    <= '0;
      rx    <= '0;
      bits  <= '0;
      cmd   <= CMD_WREN;
      phase <= PH_GAP;
      sck   <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      hcnt <= tick ? '0 : hcnt + 1'b1;
      if (tick) begin
        case (phase)
          PH_GAP: begin
            if (gcnt == GW'(GAP_TICKS - 1)) begin
              gcnt  <= '0;
              cs_n  <= 1'b0;
              phase <= PH_XFER;
              cmd   <= nxt_cmd;
              tx    <= frame_word;
              bits  <= '0;
            end else begin
              gcnt <= gcnt + 1'b1;
            end
          end
          PH_XFER: begin
            if (!sck) begin
              sck <= 1'b1;
              rx  <= {rx[6:0], miso};
            end else begin
              sck <= 1'b0;
              if (bits == (long_frame ? 4'd15 : 4'd7)) begin
                cs_n  <= 1'b1;
                phase <= PH_GAP;
                case (cmd)
                  CMD_WREN: cmd <= CMD_WRSR;
                  CMD_WRSR: begin
                    cmd   <= CMD_RDSR;
                    polls <= '0;
                  end
                  default: begin
                    if (rx[0]) begin
                      if (polls == PW'(POLL_LIMIT - 1)) begin
                        fail  <= 1'b1;
                        phase <= PH_END;
                      end else begin
                        polls <= polls + 1'b1;
                      end
                    end else begin
                      if (|rx[5:2]) fail <= 1'b1;
                      else          done <= 1'b1;
                      phase <= PH_END;
                    end
                  end
                endcase
              end else begin
                bits <= bits + 1'b1;
                tx   <= {tx[14:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [15:0] hi_clks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_clks <= '0;
    else if (!cs_n)            hi_clks <= '0;
    else if (hi_clks != '1)    hi_clks <= hi_clks + 1'b1;
  end

  // R1
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_clks >= 16'(GAP_SCK * CLK_DIV)));
  // R13
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && fail));
  // R13
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> done);
  // R13
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) fail |=> fail);
  // R13
  quiet_after_chk: assert property (@(posedge clk) disable iff (!rst_n) (done || fail) |-> cs_n);
endmodule

// File: tb/flash_unlock_seq_test.sv
module flash_unlock_seq_test;
  localparam int CLK_T = 10;
  localparam int DIV = 4;
  localparam int GAP = 2;
  localparam int PLIM = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, sel = 1'b0;
  logic sck, cs_n, mosi, done, fail;
  logic miso;
  int checks = 0, errors = 0;

  int exp_len[$];
  int exp_val[$];
  logic [7:0] stat_mem[8];
  int n_stat = 1, rd_idx = 0;

  int nb = 0, in_frame = 0, had_frame = 0;
  logic [15:0] word = '0;
  logic [7:0] op_b = '0;
  realtime t_rise = 0, t_csr = 0;

  always #(CLK_T/2) clk = ~clk;

  flash_unlock_seq #(.CLK_DIV(DIV), .GAP_SCK(GAP), .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst_n(rst_n), .wsr_en_step(en), .wsr_use_50h(sel), .miso(miso),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .done(done), .fail(fail));

  logic [7:0] cur_stat;
  assign cur_stat = stat_mem[(rd_idx < n_stat) ? rd_idx : n_stat - 1];
  assign miso = (!cs_n && nb >= 8 && nb < 16 && op_b == 8'h05) ? cur_stat[15 - nb] : 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge cs_n) begin
    if (rst_n) begin
      if (had_frame)
        chk(((($realtime - t_csr) / CLK_T) >= GAP * DIV), "R9 cs gap",
            int'(($realtime - t_csr) / CLK_T), GAP * DIV);
      in_frame = 1; nb = 0; word = '0; op_b = '0;
    end
  end

  always @(posedge sck) begin
    if (in_frame) begin
      if (nb > 0)
        chk((($realtime - t_rise) / CLK_T) == DIV, "R3 sck period",
            int'(($realtime - t_rise) / CLK_T), DIV);
      t_rise = $realtime;
      word = {word[14:0], mosi};
      nb++;
      if (nb == 8) op_b = word[7:0];
    end
  end

  always @(posedge cs_n) begin
    if (in_frame && rst_n) begin
      in_frame = 0; had_frame = 1; t_csr = $realtime;
      if (exp_len.size() == 0) begin
        chk(0, "R13 unexpected frame", int'(word), 0);
      end else begin
        automatic int el = exp_len.pop_front();
        automatic int ev = exp_val.pop_front();
        automatic int got = (nb == 8) ? int'(word[7:0]) : int'(word);
        chk(nb == el, "R7 frame length", nb, el);
        chk(got == ev, "R2 R4 R5 R6 R7 R8 frame bits MSB first", got, ev);
        if (op_b == 8'h05 && nb == 16) rd_idx++;
        if (exp_len.size() == 0) begin
          @(negedge clk);
          chk(done || fail, "R10 R11 R12 flag due with cs_n rise", {done, fail}, 1);
        end
      end
    end
  end

  task automatic push(input int len, input int val);
    exp_len.push_back(len);
    exp_val.push_back(val);
  endtask

  task automatic run(input bit e, input bit s, input int ns, input bit exp_done, input string req);
    rst_n = 1'b0; en = e; sel = s; n_stat = ns; rd_idx = 0; had_frame = 0; in_frame = 0;
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !done && !fail, "R1 reset state", {cs_n, sck, done, fail}, 4'b1000);
    rst_n = 1'b1;
    for (int i = 0; i < 4000 && !(done || fail); i++) @(negedge clk);
    repeat (40 * DIV) @(negedge clk);
    chk(exp_len.size() == 0, {req, " all frames seen"}, exp_len.size(), 0);
    chk(done == exp_done && fail == !exp_done, {req, " R13 final flags"}, {done, fail}, {exp_done, !exp_done});
    exp_len.delete(); exp_val.delete();
  endtask

  initial begin
    // R4 R10: 06h enable, clean status
    stat_mem[0] = 8'h00;
    push(8, 'h06); push(16, 'h0100); push(16, 'h0500);
    run(1, 0, 1, 1, "R4 R10");
    // R5 R8: 50h enable, busy twice
    stat_mem[0] = 8'h01; stat_mem[1] = 8'h01; stat_mem[2] = 8'h00;
    push(8, 'h50); push(16, 'h0100);
    for (int i = 0; i < 3; i++) push(16, 'h0500);
    run(1, 1, 3, 1, "R5 R8");
    // R6 R10: no enable step, bits 7,6,1 set are ignored
    stat_mem[0] = 8'hC2;
    push(16, 'h0100); push(16, 'h0500);
    run(0, 1, 1, 1, "R6 R10");
    // R11: protection bit 3 stays set
    stat_mem[0] = 8'h08;
    push(8, 'h06); push(16, 'h0100); push(16, 'h0500);
    run(1, 0, 1, 0, "R11");
    // R11: bit 5 set, no enable
    stat_mem[0] = 8'h20;
    push(16, 'h0100); push(16, 'h0500);
    run(0, 0, 1, 0, "R11 bit5");
    // R12: busy forever
    stat_mem[0] = 8'h01;
    push(16, 'h0100);
    for (int i = 0; i < PLIM; i++) push(16, 'h0500);
    run(0, 0, 1, 0, "R12 timeout");
    // R12: busy clears on the last allowed poll
    for (int i = 0; i < PLIM - 1; i++) stat_mem[i] = 8'h01;
    stat_mem[PLIM - 1] = 8'h00;
    push(16, 'h0100);
    for (int i = 0; i < PLIM; i++) push(16, 'h0500);
    run(0, 0, PLIM, 1, "R12 boundary");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule